// File: doc/BRIEF.md
# Striped Rotate-Exchange Bit Permuter

This block computes the result of a rotate-with-exchange operation on a 32-bit word. The operation generalises a right rotate: two 5-bit amounts, a primary and a secondary, are supplied, and every bit position of the datapath picks one of them according to its own index bits. A stripe control additionally inverts the chosen amount in alternating groups of the first stage. When both amounts are equal and the stripe is clear, the operation is a plain 32-bit rotate right.

Internally the source word is copied into both halves of a 64-bit working value. That value then flows through five conditional move stages with strides 16, 8, 4, 2 and 1. Each stage either copies a bit from a higher position or leaves it in place. The low 32 bits of the last stage are sign-extended to a 64-bit result. A parameter selects between a purely combinational path and a single output register with a valid flag.

Top module: `rotx_permuter`

## Requirements
- R1: The working value is the 32-bit source placed in both bits 63:32 and bits 31:0 of a 64-bit word.
- R2: The stride-16 stage touches positions 0 to 46. A position uses the primary amount when its index bit 3 is 1 and the secondary amount when it is 0. It takes the bit 16 places above it when bit 4 of that amount is 1.
- R3: When stripe is 1, the stride-16 stage inverts every bit of the selected amount for positions whose index bit 2 is 0, before bit 4 is tested. Positions whose index bit 2 is 1 are unaffected.
- R4: The stride-8 stage touches positions 0 to 38. Index bit 2 chooses the amount (1 = primary, 0 = secondary), and amount bit 3 enables the move.
- R5: The stride-4 stage touches positions 0 to 34. Index bit 1 chooses the amount (1 = primary), and amount bit 2 enables the move.
- R6: The stride-2 stage touches positions 0 to 32. Index bit 0 chooses the amount (1 = primary), and amount bit 1 enables the move.
- R7: The stride-1 stage touches positions 0 to 31 and always uses the primary amount, with amount bit 0 enabling the move. The secondary amount's bit 0 has no effect.
- R8: The result is bits 31:0 of the last stage, with bit 31 copied into result bits 63:32. Positions outside a stage's range pass through that stage unchanged.
- R9: With equal primary and secondary amounts and stripe clear, the result equals the 32-bit source rotated right by that amount, sign-extended to 64 bits, for every amount from 0 to 31.
- R10: With REGISTER_OUT = 1, out_valid rises one cycle after an in_valid strobe, with result holding the value for the inputs of that strobe. out_valid is 0 in any cycle without a strobe in the cycle before, and a synchronous reset clears it.
- R11: With REGISTER_OUT = 0, out_valid and result follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a valid operand set |
| src | input | 32 | Source word |
| amt_pri | input | 5 | Primary amount |
| amt_sec | input | 5 | Secondary amount |
| stripe | input | 1 | Stripe mode enable |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Sign-extended permuted word |

## Verification
The bench builds two copies of the block, one with REGISTER_OUT = 1 and one with REGISTER_OUT = 0. They are fed the same stimulus. The registered copy brings the one-cycle latency, back-to-back strobes, idle gaps and reset during a strobe within reach. The combinational copy checks the same values in the cycle the inputs are applied. Amount pairs are chosen so that each stride stage is enabled on its own through either amount, with the stripe set and clear. A full sweep of equal amounts checks the rotate equivalence.

// File: rtl/rotx_pkg.sv
package rotx_pkg;

    localparam int SRC_W      = 32;
    localparam int WORK_W     = 2 * SRC_W;
    localparam int AMT_W      = $clog2(SRC_W);
    localparam int NUM_STAGES = AMT_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [WORK_W-1:0] work_t;
    typedef logic [AMT_W-1:0]  amt_t;

    typedef struct packed {
        amt_t pri;
        amt_t sec;
        logic stripe;
    } rotx_ctrl_t;

    // Copy the source into both halves of the working word
    function automatic work_t dup_word(input src_t s);
        return {s, s};
    endfunction

    // Sign-extend the low half of the working word
    function automatic work_t sext_low(input work_t w);
        return {{SRC_W{w[SRC_W-1]}}, w[SRC_W-1:0]};
    endfunction

    // Highest position a stage with the given stride may move
    function automatic int stage_top(input int stride);
        return SRC_W - 2 + stride;
    endfunction

endpackage

// File: rtl/rotx_stage.sv
module rotx_stage
    import rotx_pkg::*;
#(
    parameter int AMT_BIT = 4,
    parameter bit STRIPED = 1'b0
) (
    input  work_t      din,
    input  rotx_ctrl_t ctrl,
    output work_t      dout
);
    localparam int STRIDE = 1 << AMT_BIT;
    localparam int TOP    = stage_top(STRIDE);
    localparam int SELB   = (AMT_BIT == 0) ? 0 : AMT_BIT - 1;

    for (genvar i = 0; i < WORK_W; i++) begin : g_bit
        if (i <= TOP) begin : g_mov
            localparam bit USE_PRI = (AMT_BIT == 0) || (((i >> SELB) & 1) == 1);
            localparam bit FLIP_OK = STRIPED && (((i >> 2) & 1) == 0);
            amt_t sel;
            always_comb begin
                sel = USE_PRI ? ctrl.pri : ctrl.sec;
                if (FLIP_OK && ctrl.stripe) begin
                    sel = ~sel;
                end
            end
            assign dout[i] = sel[AMT_BIT] ? din[i + STRIDE] : din[i];
        end else begin : g_pass
            assign dout[i] = din[i];
        end
    end

    // R8: with the enabling bit clear in both amounts (and no inversion), the stage is transparent
    always_comb begin
        if (!$isunknown({din, ctrl}) && !(STRIPED && ctrl.stripe) &&
            !ctrl.pri[AMT_BIT] && !ctrl.sec[AMT_BIT]) begin
            stage_idle_chk: assert (dout == din);
        end
    end

endmodule

// File: rtl/rotx_core.sv
module rotx_core
    import rotx_pkg::*;
(
    input  src_t       src,
    input  rotx_ctrl_t ctrl,
    output work_t      res
);
    work_t chain [NUM_STAGES+1];

    // R1
    assign chain[0] = dup_word(src);

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        rotx_stage #(
            .AMT_BIT (NUM_STAGES - 1 - k),
            .STRIPED (k == 0)
        ) u_stage (
            .din  (chain[k]),
            .ctrl (ctrl),
            .dout (chain[k+1])
        );
    end

    // R8
    assign res = sext_low(chain[NUM_STAGES]);

    // R9: equal amounts without stripe give a plain rotate right
    work_t rot_ref;
    always_comb begin
        rot_ref = {src, src} >> ctrl.pri;
        if (!$isunknown({src, ctrl}) && ctrl.pri == ctrl.sec && !ctrl.stripe) begin
            rotate_equiv_chk: assert (res == sext_low(rot_ref));
        end
    end

endmodule

// File: rtl/rotx_outreg.sv
module rotx_outreg
    import rotx_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  work_t din,
    output logic  out_valid,
    output work_t dout
);
    if (REGISTER_OUT) begin : g_reg
        logic  vld_q;
        work_t dat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
            end
            if (in_valid) begin
                dat_q <= din;
            end
        end

        assign out_valid = vld_q;
        assign dout      = dat_q;

        // R10
        property p_rst_clear;
            @(posedge clk) rst |=> !out_valid;
        endproperty
        rst_clear_chk: assert property (p_rst_clear);

        // R10
        property p_lat;
            @(posedge clk) disable iff (rst) in_valid |=> (out_valid && dout == $past(din));
        endproperty
        latency_chk: assert property (p_lat);

        // R10
        property p_idle;
            @(posedge clk) disable iff (rst) !in_valid |=> !out_valid;
        endproperty
        idle_chk: assert property (p_idle);

        // R8
        property p_sext;
            @(posedge clk) disable iff (rst) out_valid |-> (dout[WORK_W-1:SRC_W] == {SRC_W{dout[SRC_W-1]}});
        endproperty
        sext_chk: assert property (p_sext);
    end else begin : g_comb
        assign out_valid = in_valid;
        assign dout      = din;
    end

endmodule

// File: rtl/rotx_permuter.sv
module rotx_permuter
    import rotx_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  src,
    input  logic [AMT_W-1:0]  amt_pri,
    input  logic [AMT_W-1:0]  amt_sec,
    input  logic              stripe,
    output logic              out_valid,
    output logic [WORK_W-1:0] result
);
    rotx_ctrl_t ctrl;
    work_t      perm;

    assign ctrl = '{pri: amt_pri, sec: amt_sec, stripe: stripe};

    rotx_core u_core (
        .src  (src),
        .ctrl (ctrl),
        .res  (perm)
    );

    rotx_outreg #(
        .REGISTER_OUT (REGISTER_OUT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .din       (perm),
        .out_valid (out_valid),
        .dout      (result)
    );

endmodule

// File: tb/rotx_permuter_tb.sv
module rotx_permuter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  amt_pri = '0;
    logic [4:0]  amt_sec = '0;
    logic        stripe = 1'b0;
    logic        out_valid, c_valid;
    logic [63:0] result, c_result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [63:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    rotx_permuter #(.REGISTER_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .amt_pri(amt_pri), .amt_sec(amt_sec), .stripe(stripe),
        .out_valid(out_valid), .result(result)
    );

    rotx_permuter #(.REGISTER_OUT(1'b0)) u_dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .amt_pri(amt_pri), .amt_sec(amt_sec), .stripe(stripe),
        .out_valid(c_valid), .result(c_result)
    );

    // Specification model built from the requirement text
    function automatic logic [63:0] model(input logic [31:0] s, input logic [4:0] p,
                                          input logic [4:0] q, input logic st);
        logic [63:0] w, nw;
        logic [4:0]  a;
        w = {s, s};
        for (int b = 4; b >= 0; b--) begin
            int stride = 1 << b;
            nw = w;
            for (int i = 0; i <= 30 + stride; i++) begin
                if (b == 0) a = p;
                else a = (((i >> (b - 1)) & 1) == 1) ? p : q;
                if (b == 4 && st && (((i >> 2) & 1) == 0)) a = ~a;
                if (a[b]) nw[i] = w[i + stride];
            end
            w = nw;
        end
        return {{32{w[31]}}, w[31:0]};
    endfunction

    function automatic logic [63:0] ror_sext(input logic [31:0] s, input int r);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = s[(i + r) % 32];
        return {{32{o[31]}}, o};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] s, input logic [4:0] p, input logic [4:0] q,
                        input logic st, input logic [63:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; src = s; amt_pri = p; amt_sec = q; stripe = st;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        #1;
        check({tag, " comb R11"}, c_result, exp);
        check("R11 comb valid", {63'd0, c_valid}, 64'd1);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected items as the registered copy produces results
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, result, e.val);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R8: hand values
        send(32'h8000_0000, 5'd0, 5'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, "R8 sext neg");
        send(32'h1234_5678, 5'd0, 5'd0, 1'b0, 64'h0000_0000_1234_5678, "R8 sext pos");
        // R1: rotate by 16 needs the upper copy
        send(32'hABCD_0123, 5'd16, 5'd16, 1'b0, 64'h0000_0000_0123_ABCD, "R1 dup");
        // R7: hand values, secondary bit 0 ignored
        send(32'h0000_0001, 5'd1, 5'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, "R7 pri bit0");
        send(32'h1234_5678, 5'd0, 5'd1, 1'b0, 64'h0000_0000_1234_5678, "R7 sec ignored");
        // R2, R4, R5, R6: each stage enabled through one amount alone
        for (int b = 1; b <= 4; b++) begin
            logic [4:0] v;
            string t;
            v = 5'(1 << b);
            t = (b == 4) ? "R2" : (b == 3) ? "R4" : (b == 2) ? "R5" : "R6";
            send(32'hA5C3_0F96, v, 5'd0, 1'b0, model(32'hA5C3_0F96, v, 5'd0, 1'b0), {t, " pri"});
            send(32'hA5C3_0F96, 5'd0, v, 1'b0, model(32'hA5C3_0F96, 5'd0, v, 1'b0), {t, " sec"});
        end
        // R3: stripe patterns
        send(32'hDEAD_BEEF, 5'd0, 5'd0, 1'b1, model(32'hDEAD_BEEF, 5'd0, 5'd0, 1'b1), "R3 zero amts");
        send(32'hDEAD_BEEF, 5'd31, 5'd31, 1'b1, model(32'hDEAD_BEEF, 5'd31, 5'd31, 1'b1), "R3 full amts");
        send(32'h0F0F_33CC, 5'd16, 5'd3, 1'b1, model(32'h0F0F_33CC, 5'd16, 5'd3, 1'b1), "R3 mixed");
        idle(2);
        // R9: sweep all equal amounts
        for (int r = 0; r < 32; r++) begin
            send(32'h8E1F_3C75, 5'(r), 5'(r), 1'b0, ror_sext(32'h8E1F_3C75, r), "R9 rotate");
        end
        idle(1);
        // R2: mixed random operands, back to back
        for (int k = 0; k < 40; k++) begin
            logic [31:0] s;
            logic [4:0]  p, q;
            logic        st;
            s = $urandom; p = 5'($urandom); q = 5'($urandom); st = 1'($urandom);
            send(s, p, q, st, model(s, p, q, st), "R2 random mix");
        end
        idle(3);
        // R10: reset during a strobe clears out_valid
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;
        @(posedge clk);
        #2;
        check("R10 reset during strobe", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        idle(3);
        check("R10 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule